// File: doc/BRIEF.md
# Fully Decoded System I/O Port Block

This block is the I/O half of a home-computer gate array. It compares the whole 16-bit I/O address against a small set of ports and responds to nothing else. A processor bus writes two control registers through it. The display control register picks the screen mode, the ink/paper pair used in the high-resolution mode, and whether the frame timer may raise its interrupt. The border/audio register holds the border colour and the cassette-out (MIC) and beeper levels. On reads the block returns the display control byte, one half-row of an 8×5 keyboard matrix, or the joystick lines. It also raises a valid flag so that an outer bus mux knows when to drive the data bus.

Writes take effect at the clock edge that samples the write strobe. Read data and its valid flag are registered, so they appear one cycle after the read strobe. The keyboard port is also the border/audio port. Its low address byte is fixed, and its high byte must hold exactly one zero bit. That zero bit selects a half-row, so any other high byte is treated as an undecoded address.

Top module: `sysio_decode`

## Requirements
- R1: While reset is asserted, and at its release, scr_mode, hires_pal, border, mic_out, beep_out, rd_data and rd_valid are all 0, and tick_irq_en is 1.
- R2: A write to address 0x00FF updates the outputs at that edge. scr_mode takes data bits 2..0, with codes 000 screen 0, 001 screen 1, 010 hi-colour and 110 hi-res. hires_pal takes bits 5..3, with 000 black on white through 111 white on black. tick_irq_en becomes the inverse of bit 6.
- R3: A read of 0x00FF gives rd_valid=1 in the next cycle, and rd_data holds all 8 bits of the last byte written there.
- R4: A write to an address whose low byte is 0xFE and whose high byte has exactly one zero bit sets border to data bits 2..0, mic_out to bit 3 and beep_out to bit 4.
- R5: A read of such an address gives rd_valid=1 in the next cycle. rd_data[4:0] holds key_n[5*i+4 : 5*i], where i is the position of the zero bit in the high byte. Keys are active low, with column k in bit k. rd_data[7:5] reads 111.
- R6: A read of 0x001F gives rd_valid=1 in the next cycle. rd_data holds joy_in with its bits in place, active high: bit 0 right, 1 left, 2 down, 3 up, 4 fire, 5 and 7 extra buttons. Bit 6 reads 0.
- R7: A read of any other address gives rd_valid=0 and rd_data=0 in the next cycle. This includes 0x01FF, 0x00FE and 0x3FFE. A write to any other address, including 0x001F, leaves every control output unchanged.
- R8: In a cycle after one without a read strobe, rd_valid and rd_data are 0.
- R9: If a read and a write to 0x00FF occur in the same cycle, the read returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| key_n | input | 40 | Keyboard matrix, 8 half-rows of 5 keys, active low |
| joy_in | input | 8 | Joystick lines, active high |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | Read hit a decoded port last cycle |
| scr_mode | output | 3 | Screen mode code |
| hires_pal | output | 3 | High-resolution ink/paper code |
| tick_irq_en | output | 1 | Frame timer interrupt allowed |
| border | output | 3 | Border colour |
| mic_out | output | 1 | Cassette output level |
| beep_out | output | 1 | Beeper level |

## Verification
Each control register drives outputs directly. A corrupted register bit therefore shows at the ports in the first cycle after the bad write, or after a write that should have been ignored. For the display register, a bad bit that has no output of its own, such as bit 7, shows only on the next read-back, one cycle after the read strobe. A decode fault shows in the cycle after a read of the affected address. It appears as rd_valid set for an address that should miss, or clear for one that should hit. A wrong half-row index shows as the key bits of the wrong row on the same cycle. The bench varies the keyboard and joystick every cycle, so a stale or misrouted slice cannot stay hidden.

// File: rtl/sysio_pkg.sv
package sysio_pkg;

  localparam logic [7:0] DISP_LO = 8'hFF;
  localparam logic [7:0] KBD_LO  = 8'hFE;
  localparam logic [7:0] JOY_LO  = 8'h1F;

  typedef struct packed {
    logic       spare;
    logic       irq_off;
    logic [2:0] pal;
    logic [2:0] mode;
  } disp_t;

  typedef struct packed {
    logic       beep;
    logic       mic;
    logic [2:0] border;
  } fe_t;

  function automatic logic [7:0] kbd_byte(input logic [4:0] cols);
    return {3'b111, cols};
  endfunction

  function automatic logic [7:0] joy_byte(input logic [7:0] lines);
    return lines & 8'hBF;
  endfunction

endpackage

// File: rtl/sysio_addr_dec.sv
module sysio_addr_dec
  import sysio_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0]             addr,
  output logic                          disp_sel,
  output logic                          kbd_sel,
  output logic                          joy_sel,
  output logic [$clog2(ADDR_W-8)-1:0]   row_idx
);
  localparam int ROWS  = ADDR_W - 8;
  localparam int ROW_W = $clog2(ROWS);

  logic [ROWS-1:0] row_match;
  logic            hi_zero;

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    assign row_match[g] = (addr[ADDR_W-1:8] == ~(ROWS'(1) << g));
  end

  always_comb begin
    row_idx = '0;
    for (int i = 0; i < ROWS; i++)
      if (row_match[i]) row_idx = ROW_W'(i);
  end

  assign hi_zero  = (addr[ADDR_W-1:8] == '0);
  assign disp_sel = hi_zero && (addr[7:0] == DISP_LO);
  assign joy_sel  = hi_zero && (addr[7:0] == JOY_LO);
  assign kbd_sel  = (|row_match) && (addr[7:0] == KBD_LO);
endmodule

// File: rtl/sysio_regs.sv
module sysio_regs
  import sysio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_disp,
  input  logic       wr_fe,
  input  logic [7:0] wdata,
  output disp_t      disp_q,
  output fe_t        fe_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_q <= '0;
      fe_q   <= '0;
    end else begin
      if (wr_disp) disp_q <= disp_t'(wdata);
      if (wr_fe)   fe_q   <= fe_t'(wdata[4:0]);
    end
  end
endmodule

// File: rtl/sysio_rd_path.sv
module sysio_rd_path
  import sysio_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd,
  input  logic                     disp_sel,
  input  logic                     kbd_sel,
  input  logic                     joy_sel,
  input  logic [$clog2(ROWS)-1:0]  row_idx,
  input  logic [ROWS*COLS-1:0]     key_n,
  input  logic [7:0]               joy_in,
  input  disp_t                    disp_q,
  output logic [7:0]               rd_data,
  output logic                     rd_valid
);
  logic [COLS-1:0] rows_a [ROWS];
  logic [7:0]      mux_d;
  logic            hit;

  for (genvar g = 0; g < ROWS; g++) begin : g_slice
    assign rows_a[g] = key_n[g*COLS +: COLS];
  end

  assign hit = disp_sel | kbd_sel | joy_sel;

  always_comb begin
    mux_d = '0;
    if (disp_sel)     mux_d = disp_q;
    else if (kbd_sel) mux_d = kbd_byte(rows_a[row_idx]);
    else if (joy_sel) mux_d = joy_byte(joy_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd && hit;
      rd_data  <= (rd && hit) ? mux_d : '0;
    end
  end
endmodule

// File: rtl/sysio_decode.sv
module sysio_decode
  import sysio_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int COLS   = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              io_addr,
  input  logic                           io_rd,
  input  logic                           io_wr,
  input  logic [7:0]                     io_wdata,
  input  logic [(ADDR_W-8)*COLS-1:0]     key_n,
  input  logic [7:0]                     joy_in,
  output logic [7:0]                     rd_data,
  output logic                           rd_valid,
  output logic [2:0]                     scr_mode,
  output logic [2:0]                     hires_pal,
  output logic                           tick_irq_en,
  output logic [2:0]                     border,
  output logic                           mic_out,
  output logic                           beep_out
);
  localparam int ROWS  = ADDR_W - 8;
  localparam int ROW_W = $clog2(ROWS);

  logic             disp_sel, kbd_sel, joy_sel;
  logic [ROW_W-1:0] row_idx;
  logic             wr_disp_ev, wr_fe_ev;
  disp_t            disp_q;
  fe_t              fe_q;

  sysio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr     (io_addr),
    .disp_sel (disp_sel),
    .kbd_sel  (kbd_sel),
    .joy_sel  (joy_sel),
    .row_idx  (row_idx)
  );

  assign wr_disp_ev = io_wr && disp_sel;
  assign wr_fe_ev   = io_wr && kbd_sel;

  sysio_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_disp (wr_disp_ev),
    .wr_fe   (wr_fe_ev),
    .wdata   (io_wdata),
    .disp_q  (disp_q),
    .fe_q    (fe_q)
  );

  sysio_rd_path #(.ROWS(ROWS), .COLS(COLS)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd       (io_rd),
    .disp_sel (disp_sel),
    .kbd_sel  (kbd_sel),
    .joy_sel  (joy_sel),
    .row_idx  (row_idx),
    .key_n    (key_n),
    .joy_in   (joy_in),
    .disp_q   (disp_q),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  assign scr_mode    = disp_q.mode;
  assign hires_pal   = disp_q.pal;
  assign tick_irq_en = ~disp_q.irq_off;
  assign border      = fe_q.border;
  assign mic_out     = fe_q.mic;
  assign beep_out    = fe_q.beep;
endmodule

// File: rtl/sysio_decode_chk.sv
module sysio_decode_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       io_rd,
  input logic [7:0] io_wdata,
  input logic       disp_sel,
  input logic       kbd_sel,
  input logic       joy_sel,
  input logic       wr_disp_ev,
  input logic       wr_fe_ev,
  input logic [7:0] rd_data,
  input logic       rd_valid,
  input logic [2:0] scr_mode,
  input logic [2:0] hires_pal,
  input logic       tick_irq_en,
  input logic [2:0] border,
  input logic       mic_out,
  input logic       beep_out
);
  assert_disp_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_disp_ev |=> scr_mode == $past(io_wdata[2:0]) && hires_pal == $past(io_wdata[5:3])
                   && tick_irq_en == !$past(io_wdata[6]));

  assert_fe_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fe_ev |=> border == $past(io_wdata[2:0]) && mic_out == $past(io_wdata[3])
                 && beep_out == $past(io_wdata[4]));

  assert_disp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_disp_ev |=> $stable({scr_mode, hires_pal, tick_irq_en}));

  assert_fe_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fe_ev |=> $stable({border, mic_out, beep_out}));

  assert_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !(disp_sel || kbd_sel || joy_sel)) |=> !rd_valid && rd_data == 8'h00);

  assert_sel_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({disp_sel, kbd_sel, joy_sel}));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> !rd_valid && rd_data == 8'h00);

  assert_kbd_pad_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && kbd_sel) |=> rd_valid && rd_data[7:5] == 3'b111);

  assert_joy_bit6_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && joy_sel) |=> rd_valid && !rd_data[6]);
endmodule

bind sysio_decode sysio_decode_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .io_rd       (io_rd),
  .io_wdata    (io_wdata),
  .disp_sel    (disp_sel),
  .kbd_sel     (kbd_sel),
  .joy_sel     (joy_sel),
  .wr_disp_ev  (wr_disp_ev),
  .wr_fe_ev    (wr_fe_ev),
  .rd_data     (rd_data),
  .rd_valid    (rd_valid),
  .scr_mode    (scr_mode),
  .hires_pal   (hires_pal),
  .tick_irq_en (tick_irq_en),
  .border      (border),
  .mic_out     (mic_out),
  .beep_out    (beep_out)
);

// File: tb/sysio_decode_test.sv
module sysio_decode_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [39:0] key_n = '1;
  logic [7:0]  joy_in = '0;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic [2:0]  scr_mode, hires_pal, border;
  logic        tick_irq_en, mic_out, beep_out;

  int checks = 0, fails = 0;
  logic [7:0] m_disp = 8'h00;
  logic [4:0] m_fe = 5'h00;
  logic [7:0] e_rdd = 8'h00;
  logic       e_rdv = 1'b0;

  sysio_decode uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected read result, restated from the requirement text.
  function automatic logic [8:0] ref_read(input logic [15:0] a);
    if (a == 16'h00FF) return {1'b1, m_disp};
    if (a == 16'h001F) return {1'b1, joy_in[7], 1'b0, joy_in[5:0]};
    if (a[7:0] == 8'hFE)
      for (int r = 0; r < 8; r++)
        if (a[15:8] == (8'hFF ^ (8'h01 << r)))
          return {1'b1, 3'b111, key_n[r*5 +: 5]};
    return 9'h000;
  endfunction

  task automatic compare_all(input string tag);
    check({tag, " rd_valid"}, 16'(rd_valid), 16'(e_rdv));
    check({tag, " rd_data"}, 16'(rd_data), 16'(e_rdd));
    check({tag, "/R2 display outputs"}, 16'({scr_mode, hires_pal, tick_irq_en}),
          16'({m_disp[2:0], m_disp[5:3], ~m_disp[6]}));
    check({tag, "/R4 border outputs"}, 16'({border, mic_out, beep_out}),
          16'({m_fe[2:0], m_fe[3], m_fe[4]}));
  endtask

  task automatic cycle(input logic rd, input logic wr, input logic [15:0] a,
                       input logic [7:0] d, input string tag);
    logic [8:0] r;
    io_rd = rd; io_wr = wr; io_addr = a; io_wdata = d;
    r = ref_read(a);
    e_rdv = rd && r[8];
    e_rdd = e_rdv ? r[7:0] : 8'h00;
    if (wr && a == 16'h00FF) m_disp = d;
    if (wr && a[7:0] == 8'hFE && ref_read(a)) m_fe = d[4:0];
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog R1..sequence actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare_all("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1 after release");

    // R2: mode and palette codes, interrupt disable bit
    cycle(0, 1, 16'h00FF, 8'b0100_0110, "R2 hires pal0 irq off");
    cycle(0, 1, 16'h00FF, 8'b0011_1010, "R2 hicolour pal7");
    cycle(1, 0, 16'h00FF, 8'h00, "R3 readback");
    cycle(1, 1, 16'h00FF, 8'hC1, "R9 read with write");
    cycle(1, 0, 16'h00FF, 8'h00, "R3 readback full byte");
    cycle(0, 0, 16'h00FF, 8'h00, "R8 idle");

    // R4 / R5 each half-row
    for (int r = 0; r < 8; r++) begin
      key_n = ~(40'h1F << (r*5)) ^ (40'h1 << (r*5 + r % 5));
      cycle(0, 1, {8'hFF ^ (8'h01 << r), 8'hFE}, 8'(r * 3 + 8'h10), "R4 border write");
      cycle(1, 0, {8'hFF ^ (8'h01 << r), 8'hFE}, 8'h00, "R5 keyboard row");
    end

    joy_in = 8'hFF;
    cycle(1, 0, 16'h001F, 8'h00, "R6 joystick all");
    joy_in = 8'hA5;
    cycle(1, 0, 16'h001F, 8'h00, "R6 joystick pattern");

    // R7 misses and ignored writes
    cycle(1, 0, 16'h01FF, 8'h00, "R7 read 01FF");
    cycle(1, 0, 16'h00FE, 8'h00, "R7 read 00FE");
    cycle(1, 0, 16'h3FFE, 8'h00, "R7 read 3FFE");
    cycle(0, 1, 16'h001F, 8'hFF, "R7 write joystick");
    cycle(0, 1, 16'h3FFE, 8'h1F, "R7 write 3FFE");
    cycle(0, 1, 16'h80FF, 8'hFF, "R7 write 80FF");
    cycle(1, 0, 16'h00FF, 8'h00, "R7 display unchanged");

    // Random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      string tg;
      key_n = {$urandom, $urandom};
      joy_in = 8'($urandom);
      case ($urandom % 6)
        0: begin a = 16'h00FF; tg = "R3 random display"; end
        1: begin a = 16'h001F; tg = "R6 random joystick"; end
        2: begin a = {8'hFF ^ (8'h01 << ($urandom % 8)), 8'hFE}; tg = "R5 random keyboard"; end
        3: begin a = {8'(($urandom % 2) ? 8'h3F : 8'h01), 8'(($urandom % 2) ? 8'hFE : 8'hFF)}; tg = "R7 random miss"; end
        default: begin a = 16'($urandom); tg = "R7 random address"; end
      endcase
      cycle($urandom % 2 == 1, $urandom % 3 == 0, a, 8'($urandom), tg);
    end
    cycle(0, 0, 16'h0000, 8'h00, "R8 final idle");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule